// File: doc/BRIEF.md
# Process-Tagged Translation Cache with Access Protection

This block caches page translations for a processor's memory pipeline. Every slot holds a virtual page number, the identifier of the process that owns it, a physical page number and three attribute flags: writable, user-accessible and dirty. A slot also has a valid bit. A lookup is purely combinational. It compares the presented page number and process identifier against every valid slot at once. The result is a usable translation, a protection fault, or a miss.

A page walker outside this block answers misses through the refill port. The written slot is chosen in this order: a slot already holding the same page and process, then the lowest free slot, then a round-robin victim. On a context switch, the caller has two choices, picked by a mode input. It can clear the whole cache. Or, because slots carry an owner tag, it can clear only the slots of the outgoing process and leave the others usable.

Top module: `tagged_tlb`

## Requirements
- R1: After reset every slot is invalid, so any lookup gives `lk_hit`=0, `lk_fault`=0, `lk_dirty`=0 and `lk_ppn`=0.
- R2: A lookup matches a slot only when the slot is valid and both its page number and its process identifier equal `lk_vpn` and `lk_pid`. Equal page numbers owned by different processes are separate translations. The lookup result is combinational in the same cycle.
- R3: On a usable hit, `lk_ppn` carries the slot's physical page number and `lk_dirty` its dirty flag. Whenever `lk_hit` is 0, `lk_ppn` is 0 and `lk_dirty` is 0.
- R4: A match raises `lk_fault` and holds `lk_hit` low in two cases. The first is `lk_write`=1 to a slot whose writable flag is 0. The second is `lk_user`=1 (user access) to a slot whose user flag is 0 (supervisor page). `lk_hit` and `lk_fault` are never both 1.
- R5: A refill (`fill_en`=1) is written at the next rising clock edge. If a valid slot already holds the same page and process, that slot is overwritten, so at most one slot ever matches a lookup.
- R6: A new refill goes to the lowest-indexed invalid slot. When all slots are valid, it replaces the slot named by a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping at the last slot, only when it is used for a replacement.
- R7: `ctx_switch`=1 with `sel_mode`=0 invalidates every slot at the next edge.
- R8: `ctx_switch`=1 with `sel_mode`=1 invalidates at the next edge only the slots whose process identifier equals `old_pid`. All other slots keep hitting.
- R9: A refill presented in the same cycle as `ctx_switch`=1 is discarded and writes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 8 | Lookup process identifier |
| lk_write | input | 1 | Lookup is a write |
| lk_user | input | 1 | Lookup comes from user mode |
| lk_hit | output | 1 | Usable translation found |
| lk_fault | output | 1 | Matching slot forbids this access |
| lk_ppn | output | 20 | Physical page number on hit, else 0 |
| lk_dirty | output | 1 | Dirty flag of the hit slot |
| fill_en | input | 1 | Refill request |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_pid | input | 8 | Refill process identifier |
| fill_ppn | input | 20 | Refill physical page number |
| fill_writable | input | 1 | Refill page is writable |
| fill_user | input | 1 | Refill page is user-accessible |
| fill_dirty | input | 1 | Refill page is dirty |
| ctx_switch | input | 1 | Context-switch invalidate pulse |
| sel_mode | input | 1 | 0: clear all slots, 1: clear slots of `old_pid` only |
| old_pid | input | 8 | Outgoing process for selective invalidate |

## Verification
A corrupted valid bit or owner tag shows up at the ports in the same cycle. The next lookup of that page either misses when it should hit, or returns another process's frame. A wrong flag shows up the same way, as a fault where a hit was due or the reverse. A victim pointer that drifts stays hidden while free slots remain. It appears only after the cache is full, on the refill after the one that went wrong, when a translation that should have survived is gone. For that reason the replacement checks fill the cache completely and probe the neighbours of every replaced slot.

// File: rtl/tagged_tlb_pkg.sv
// Package: shared widths and the payload record of one translation slot.
// Assumes: the widths are fixed for the whole chip; the top only chooses depth.
package tagged_tlb_pkg;
    parameter int VPN_W = 20;
    parameter int PPN_W = 20;
    parameter int PID_W = 8;

    // Payload held beside each tag.
    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             writable;
        logic             user;
        logic             dirty;
    } slot_data_t;
endpackage

// File: rtl/tlb_slot_store.sv
// Module: register array of translation slots with owner-tagged invalidation.
// Assumes: wr_en is never high together with inv_all or inv_pid_en (top gates it).
module tlb_slot_store
    import tagged_tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PID_W-1:0] wr_pid,
    input  slot_data_t       wr_data,
    input  logic             inv_all,
    input  logic             inv_pid_en,
    input  logic [PID_W-1:0] inv_pid,
    output logic [ENTRIES-1:0] valid_q,
    output logic [VPN_W-1:0] vpn_q  [ENTRIES],
    output logic [PID_W-1:0] pid_q  [ENTRIES],
    output slot_data_t       data_q [ENTRIES]
);

    // Valid bits: reset, full clear, per-owner clear, then refill set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inv_all) begin
            valid_q <= '0;
        end else begin
            if (inv_pid_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (pid_q[i] == inv_pid) valid_q[i] <= 1'b0;
                end
            end
            if (wr_en) valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and payload storage: cleared on reset, written by refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i]  <= '0;
                pid_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (wr_en) begin
            vpn_q[wr_idx]  <= wr_vpn;
            pid_q[wr_idx]  <= wr_pid;
            data_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/tlb_tag_cmp.sv
// Module: parallel comparison of one page/process key against all slot tags.
// Assumes: the caller keeps at most one valid slot per key, so the result is one-hot or zero.
module tlb_tag_cmp
    import tagged_tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic [ENTRIES-1:0] valid,
    input  logic [VPN_W-1:0]   tag_vpn [ENTRIES],
    input  logic [PID_W-1:0]   tag_pid [ENTRIES],
    input  logic [VPN_W-1:0]   key_vpn,
    input  logic [PID_W-1:0]   key_pid,
    output logic [ENTRIES-1:0] match
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        // One comparator per slot: valid, page and owner must all agree.
        assign match[g] = valid[g] && (tag_vpn[g] == key_vpn) && (tag_pid[g] == key_pid);
    end
endmodule

// File: rtl/tlb_victim_sel.sv
// Module: chooses the slot a refill writes: same-key slot, else lowest free, else round robin.
// Assumes: commit is high only in a cycle where the refill is really written.
module tlb_victim_sel #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid,
    input  logic [ENTRIES-1:0] key_match,
    input  logic               commit,
    output logic [IDX_W-1:0]   idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;
    logic             same_any;
    logic             free_any;

    // Encode the same-key slot and the lowest free slot, then pick the target.
    always_comb begin
        same_any = |key_match;
        free_any = ~&valid;
        same_idx = '0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (key_match[i]) same_idx = IDX_W'(i);
        end
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        if (same_any)      idx = same_idx;
        else if (free_any) idx = free_idx;
        else               idx = rr_q;
    end

    // Round-robin pointer: moves only when it supplied the replaced slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (commit && !same_any && !free_any) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/tagged_tlb.sv
// Module: fully associative, process-tagged translation cache with permission check.
// Assumes: lookup is combinational; refill and invalidation act at the next edge;
// a refill coinciding with a context switch is dropped.
module tagged_tlb
    import tagged_tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PID_W-1:0] lk_pid,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic             lk_fault,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_writable,
    input  logic             fill_user,
    input  logic             fill_dirty,
    input  logic             ctx_switch,
    input  logic             sel_mode,
    input  logic [PID_W-1:0] old_pid
);
    logic [ENTRIES-1:0] ent_valid;
    logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
    logic [PID_W-1:0]   ent_pid  [ENTRIES];
    slot_data_t         ent_data [ENTRIES];
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fill_match;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_commit;
    slot_data_t         fill_data;
    slot_data_t         sel_data;
    logic               any_match;
    logic               perm_bad;

    assign fill_commit = fill_en && !ctx_switch;
    assign fill_data   = '{ppn: fill_ppn, writable: fill_writable, user: fill_user, dirty: fill_dirty};

    tlb_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fill_commit),
        .wr_idx     (fill_idx),
        .wr_vpn     (fill_vpn),
        .wr_pid     (fill_pid),
        .wr_data    (fill_data),
        .inv_all    (ctx_switch && !sel_mode),
        .inv_pid_en (ctx_switch && sel_mode),
        .inv_pid    (old_pid),
        .valid_q    (ent_valid),
        .vpn_q      (ent_vpn),
        .pid_q      (ent_pid),
        .data_q     (ent_data)
    );

    tlb_tag_cmp #(.ENTRIES(ENTRIES)) u_lk_cmp (
        .valid   (ent_valid),
        .tag_vpn (ent_vpn),
        .tag_pid (ent_pid),
        .key_vpn (lk_vpn),
        .key_pid (lk_pid),
        .match   (lk_match)
    );

    tlb_tag_cmp #(.ENTRIES(ENTRIES)) u_fill_cmp (
        .valid   (ent_valid),
        .tag_vpn (ent_vpn),
        .tag_pid (ent_pid),
        .key_vpn (fill_vpn),
        .key_pid (fill_pid),
        .match   (fill_match)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (ent_valid),
        .key_match (fill_match),
        .commit    (fill_commit),
        .idx       (fill_idx)
    );

    // Select the payload of the matching slot (match is one-hot or zero).
    always_comb begin
        sel_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) sel_data = ent_data[i];
        end
    end

    // Permission check and result gating for the lookup port.
    always_comb begin
        any_match = |lk_match;
        perm_bad  = (lk_write && !sel_data.writable) || (lk_user && !sel_data.user);
        lk_fault  = any_match && perm_bad;
        lk_hit    = any_match && !perm_bad;
        lk_ppn    = lk_hit ? sel_data.ppn : '0;
        lk_dirty  = lk_hit && sel_data.dirty;
    end
endmodule

// File: rtl/tagged_tlb_chk.sv
// Module: protocol and state checker bound to tagged_tlb.
// Assumes: sampled at the rising edge; all properties disabled during reset.
module tagged_tlb_chk
    import tagged_tlb_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic [PPN_W-1:0]   lk_ppn,
    input logic               lk_dirty,
    input logic               fill_en,
    input logic               ctx_switch,
    input logic               sel_mode,
    input logic [ENTRIES-1:0] ent_valid,
    input logic [ENTRIES-1:0] lk_match
);
    assert_hit_fault_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));

    assert_fault_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_match != '0));

    assert_ppn_zero_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_ppn == '0));

    assert_dirty_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_dirty |-> lk_hit);

    assert_single_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !ctx_switch) |=> (ent_valid != '0));

    assert_flush_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_switch && !sel_mode) |=> (ent_valid == '0));

    assert_selective_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_switch && sel_mode) |=> ($countones(ent_valid) <= $past($countones(ent_valid))));
endmodule

bind tagged_tlb tagged_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_hit     (lk_hit),
    .lk_fault   (lk_fault),
    .lk_ppn     (lk_ppn),
    .lk_dirty   (lk_dirty),
    .fill_en    (fill_en),
    .ctx_switch (ctx_switch),
    .sel_mode   (sel_mode),
    .ent_valid  (ent_valid),
    .lk_match   (lk_match)
);

// File: tb/tagged_tlb_tb.sv
// Bench: vector table of lookups over a prepared set, then directed refill,
// invalidation and replacement tests. Inputs change on falling edges.
module tagged_tlb_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_pid = '0;
    logic        lk_write = 1'b0;
    logic        lk_user = 1'b1;
    logic        lk_hit, lk_fault, lk_dirty;
    logic [19:0] lk_ppn;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_pid = '0;
    logic [19:0] fill_ppn = '0;
    logic        fill_writable = 1'b0;
    logic        fill_user = 1'b0;
    logic        fill_dirty = 1'b0;
    logic        ctx_switch = 1'b0;
    logic        sel_mode = 1'b0;
    logic [7:0]  old_pid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tagged_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_write(lk_write), .lk_user(lk_user),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_ppn(lk_ppn), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid), .fill_ppn(fill_ppn),
        .fill_writable(fill_writable), .fill_user(fill_user), .fill_dirty(fill_dirty),
        .ctx_switch(ctx_switch), .sel_mode(sel_mode), .old_pid(old_pid)
    );

    // {vpn, pid, write, user, exp_hit, exp_fault, exp_dirty, exp_ppn}
    localparam int VW = 20 + 8 + 1 + 1 + 1 + 1 + 1 + 20;
    localparam int NV = 8;
    localparam logic [VW-1:0] VEC [NV] = '{
        {20'h00005, 8'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00064},
        {20'h00005, 8'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 20'h000C8},
        {20'h00005, 8'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 20'h00000},
        {20'h00005, 8'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 20'h00064},
        {20'h00ABC, 8'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 20'h00000},
        {20'h00ABC, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 20'h12345},
        {20'h00ABC, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000},
        {20'h00006, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h00000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic look(input logic [19:0] v, input logic [7:0] p, input logic w, input logic u);
        @(negedge clk);
        lk_vpn = v; lk_pid = p; lk_write = w; lk_user = u;
        #2;
    endtask

    task automatic fill(input logic [19:0] v, input logic [7:0] p, input logic [19:0] f,
                        input logic w, input logic u, input logic d);
        @(negedge clk);
        fill_en = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = f;
        fill_writable = w; fill_user = u; fill_dirty = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic ctx(input logic m, input logic [7:0] p);
        @(negedge clk);
        ctx_switch = 1'b1; sel_mode = m; old_pid = p;
        @(negedge clk);
        ctx_switch = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        look(20'h00005, 8'd1, 1'b0, 1'b1);
        chk("R1 hit", {31'd0, lk_hit}, 32'd0);
        chk("R1 fault", {31'd0, lk_fault}, 32'd0);
        chk("R1 ppn", {12'd0, lk_ppn}, 32'd0);
        chk("R1 dirty", {31'd0, lk_dirty}, 32'd0);

        // Prepared set: same page for two processes, one supervisor page.
        fill(20'h00005, 8'd1, 20'h00064, 1'b1, 1'b1, 1'b0);
        fill(20'h00005, 8'd2, 20'h000C8, 1'b0, 1'b1, 1'b1);
        fill(20'h00ABC, 8'd1, 20'h12345, 1'b1, 1'b0, 1'b1);

        // Vector walk covering R2 R3 R4.
        for (int k = 0; k < NV; k++) begin
            look(VEC[k][VW-1 -: 20], VEC[k][VW-21 -: 8], VEC[k][VW-29], VEC[k][VW-30]);
            chk($sformatf("R2 vec%0d hit", k), {31'd0, lk_hit}, {31'd0, VEC[k][22]});
            chk($sformatf("R4 vec%0d fault", k), {31'd0, lk_fault}, {31'd0, VEC[k][21]});
            chk($sformatf("R3 vec%0d dirty", k), {31'd0, lk_dirty}, {31'd0, VEC[k][20]});
            chk($sformatf("R3 vec%0d ppn", k), {12'd0, lk_ppn}, {12'd0, VEC[k][19:0]});
        end

        // R5: refill of an existing key overwrites it.
        fill(20'h00005, 8'd1, 20'h00777, 1'b1, 1'b1, 1'b0);
        look(20'h00005, 8'd1, 1'b0, 1'b1);
        chk("R5 overwrite ppn", {12'd0, lk_ppn}, 32'h00777);

        // R8 and R9: selective invalidate of pid 2 with a simultaneous refill.
        @(negedge clk);
        ctx_switch = 1'b1; sel_mode = 1'b1; old_pid = 8'd2;
        fill_en = 1'b1; fill_vpn = 20'h00099; fill_pid = 8'd3; fill_ppn = 20'h00042;
        fill_writable = 1'b1; fill_user = 1'b1; fill_dirty = 1'b0;
        @(negedge clk);
        ctx_switch = 1'b0; fill_en = 1'b0;
        look(20'h00005, 8'd2, 1'b0, 1'b1);
        chk("R8 outgoing pid cleared", {31'd0, lk_hit}, 32'd0);
        look(20'h00005, 8'd1, 1'b0, 1'b1);
        chk("R8 other pid kept", {31'd0, lk_hit}, 32'd1);
        look(20'h00ABC, 8'd1, 1'b1, 1'b0);
        chk("R8 other pid kept ppn", {12'd0, lk_ppn}, 32'h12345);
        look(20'h00099, 8'd3, 1'b0, 1'b1);
        chk("R9 fill dropped", {31'd0, lk_hit}, 32'd0);

        // R7: flush everything.
        ctx(1'b0, 8'd0);
        look(20'h00005, 8'd1, 1'b0, 1'b1);
        chk("R7 flush pid1 page5", {31'd0, lk_hit}, 32'd0);
        look(20'h00ABC, 8'd1, 1'b1, 1'b0);
        chk("R7 flush pid1 pageABC", {31'd0, lk_hit}, 32'd0);

        // R6: fill all 32 slots; slot 10 belongs to pid 5.
        for (int i = 0; i < 32; i++) begin
            fill(20'h00100 + 20'(i), (i == 10) ? 8'd5 : 8'd4, 20'h01000 + 20'(i), 1'b1, 1'b1, 1'b0);
        end
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 32; i++) begin
                look(20'h00100 + 20'(i), (i == 10) ? 8'd5 : 8'd4, 1'b0, 1'b1);
                if (!lk_hit || lk_ppn != 20'h01000 + 20'(i)) bad++;
            end
            chk("R6 all slots filled", 32'(bad), 32'd0);
        end

        // R6: full cache, round robin from slot 0.
        fill(20'h00200, 8'd4, 20'h02000, 1'b1, 1'b1, 1'b0);
        look(20'h00100, 8'd4, 1'b0, 1'b1);
        chk("R6 slot0 replaced", {31'd0, lk_hit}, 32'd0);
        look(20'h00101, 8'd4, 1'b0, 1'b1);
        chk("R6 slot1 kept", {31'd0, lk_hit}, 32'd1);
        look(20'h00200, 8'd4, 1'b0, 1'b1);
        chk("R6 new entry ppn", {12'd0, lk_ppn}, 32'h02000);
        fill(20'h00201, 8'd4, 20'h02001, 1'b1, 1'b1, 1'b0);
        look(20'h00101, 8'd4, 1'b0, 1'b1);
        chk("R6 slot1 replaced", {31'd0, lk_hit}, 32'd0);

        // R6: a freed slot is used before the pointer.
        ctx(1'b1, 8'd5);
        look(20'h0010A, 8'd5, 1'b0, 1'b1);
        chk("R8 pid5 cleared", {31'd0, lk_hit}, 32'd0);
        fill(20'h00202, 8'd4, 20'h02002, 1'b1, 1'b1, 1'b0);
        look(20'h00202, 8'd4, 1'b0, 1'b1);
        chk("R6 free slot used", {12'd0, lk_ppn}, 32'h02002);
        look(20'h00102, 8'd4, 1'b0, 1'b1);
        chk("R6 pointer not consumed", {31'd0, lk_hit}, 32'd1);
        fill(20'h00203, 8'd4, 20'h02003, 1'b1, 1'b1, 1'b0);
        look(20'h00102, 8'd4, 1'b0, 1'b1);
        chk("R6 slot2 replaced", {31'd0, lk_hit}, 32'd0);
        look(20'h00103, 8'd4, 1'b0, 1'b1);
        chk("R6 slot3 kept", {31'd0, lk_hit}, 32'd1);

        finish_run();
    end
endmodule